// File: doc/BRIEF.md
# Completion Pointer Queues with Interrupt Aggregation

This block holds a set of small hardware queues of descriptor pointers, each with room for a fixed number of entries (16 by default). A producer writes pointers through a push port, and the host removes them through a pop port. Each queue drives a level signal that stays high while it holds any entry. When a queue goes from empty to non-empty it emits a one-cycle up event. When the host drains it back to empty it emits a one-cycle down event.

An aggregator turns these events into bits of an interrupt status vector. Each queue has a programmable selector that names one of the status bits. An up event sets the selected bit. A down event clears it, unless another queue that selects the same bit still holds entries. A per-bit enable mask gates the status vector onto a single host interrupt line. The selectors and the mask are written through a simple register write port. The status bits follow queue occupancy, so software never has to clear them.

Top module: `cqia_top`

## Requirements
- R1: `q_pending[q]` is high in every cycle in which queue q holds at least one entry, and low otherwise.
- R2: Accepted pushes to a queue are popped in arrival order. The popped pointer appears on `pop_ptr` in the cycle after the pop and holds its value until the next pop.
- R3: `q_up[q]` pulses, in the cycle of the push, only when a push reaches an empty queue q. The next edge sets `irq_status` at the bit position given by q's selector. A push to a non-empty queue produces no up event.
- R4: `irq` is high exactly when some `irq_status` bit is set and its enable mask bit is 1. A set status bit whose enable is 0 does not raise `irq`.
- R5: A pop that leaves queue q empty pulses `q_down[q]` in the cycle of the pop. The next edge clears the selected status bit, and `irq` falls if no other enabled bit is set.
- R6: When several queues select the same status bit, the bit stays set until every one of them is empty.
- R7: A push to a full queue is dropped and sets the sticky `q_overflow[q]`. The stored entries are unchanged and still pop in order.
- R8: A pop from an empty queue loads 0 into `pop_ptr` and sets the sticky `q_underflow[q]`.
- R9: A push and a pop on the same queue in the same cycle, with one entry held, produce neither `q_up` nor `q_down`. The queue still holds one entry, the new pointer.
- R10: A register write with `cfg_addr` < NUM_Q loads that queue's selector from the low log2(NUM_BITS) bits of `cfg_wdata`. A write with `cfg_addr` == NUM_Q loads the enable mask from `cfg_wdata`. After reset, queue q selects bit q mod NUM_BITS and the mask is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Push request |
| push_qid | input | QW | Target queue of the push |
| push_ptr | input | PTR_W | Pointer to store |
| pop_en | input | 1 | Pop request |
| pop_qid | input | QW | Queue to pop |
| pop_ptr | output | PTR_W | Pointer from the last pop, or 0 after an empty pop |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Selector index (0..NUM_Q-1) or mask (NUM_Q) |
| cfg_wdata | input | NUM_BITS | Write data |
| q_pending | output | NUM_Q | Per-queue non-empty level |
| q_up | output | NUM_Q | Per-queue empty-to-non-empty event |
| q_down | output | NUM_Q | Per-queue drained-to-empty event |
| q_overflow | output | NUM_Q | Sticky: a push was dropped on a full queue |
| q_underflow | output | NUM_Q | Sticky: a pop was made on an empty queue |
| irq_status | output | NUM_BITS | Interrupt status vector |
| irq | output | 1 | Host interrupt line |

## Verification
The hardest situations to reach are the edges of queue occupancy. One is a queue that is exactly full when one more push arrives. The other is a queue holding exactly one entry that is pushed and popped in the same cycle. The bench reaches the first by filling one queue with sixteen distinct pointers before the extra push, then draining it to prove the contents were not disturbed. It reaches the second by loading one entry and then issuing a combined push and pop. In that cycle it observes the event outputs, and afterwards it checks which pointer remains. The shared-bit case is set up by remapping a queue onto another queue's status bit and then draining the two queues one at a time.

// File: rtl/cqia_pkg.sv
package cqia_pkg;
   // index width that never collapses to zero bits
   function automatic int clog2_min1(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction
endpackage

// File: rtl/cqia_ptr_fifo.sv
module cqia_ptr_fifo
   import cqia_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [PTR_W-1:0] din,
   output logic [PTR_W-1:0] head,
   output logic             not_empty,
   output logic             nxt_not_empty,
   output logic             up_evt,
   output logic             down_evt,
   output logic             ovf,
   output logic             unf
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = clog2_min1(DEPTH);
   localparam logic [CW-1:0] FULL = CW'(DEPTH);
   localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

   logic [PTR_W-1:0] mem [DEPTH];
   logic [IW-1:0]    rd_idx, wr_idx;
   logic [CW-1:0]    count, count_nxt;
   logic             push_ok, pop_ok;

   assign push_ok = push && (count != FULL);
   assign pop_ok  = pop && (count != '0);

   always_comb begin
      count_nxt = count;
      if (push_ok && !pop_ok)      count_nxt = count + 1'b1;
      else if (!push_ok && pop_ok) count_nxt = count - 1'b1;
   end

   assign up_evt        = push_ok && (count == '0);
   assign down_evt      = pop_ok && !push_ok && (count == CW'(1));
   assign not_empty     = (count != '0);
   assign nxt_not_empty = (count_nxt != '0);
   assign head          = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_idx] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= '0;
         rd_idx <= '0;
         wr_idx <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else begin
         count <= count_nxt;
         if (push_ok) wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + 1'b1;
         if (pop_ok)  rd_idx <= (rd_idx == LAST) ? '0 : rd_idx + 1'b1;
         if (push && !push_ok) ovf <= 1'b1;
         if (pop && !pop_ok)   unf <= 1'b1;
      end
   end

   AST_UP_LANDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      up_evt |=> (count == CW'(1))); // R3
   AST_DOWN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      down_evt |=> !not_empty); // R5
   AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (count == FULL && push && !pop) |=> (count == FULL && ovf)); // R7
   AST_EMPTY_POP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop && !push) |=> (unf && !not_empty)); // R8
   AST_SWAP_STAYS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(1) && push && pop) |=> (count == CW'(1))); // R9
endmodule

// File: rtl/cqia_cfg_regs.sv
module cqia_cfg_regs
   import cqia_pkg::*;
#(
   parameter int NUM_Q    = 4,
   parameter int NUM_BITS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [clog2_min1(NUM_Q+1)-1:0] addr,
   input  logic [NUM_BITS-1:0]        wdata,
   output logic [NUM_Q*clog2_min1(NUM_BITS)-1:0] sel_flat,
   output logic [NUM_BITS-1:0]        en_mask
);
   localparam int SW = clog2_min1(NUM_BITS);
   localparam int AW = clog2_min1(NUM_Q + 1);

   for (genvar q = 0; q < NUM_Q; q++) begin : g_sel
      always_ff @(posedge clk) begin
         if (!rst_n)
            sel_flat[q*SW +: SW] <= SW'(q % NUM_BITS);
         else if (we && addr == AW'(q))
            sel_flat[q*SW +: SW] <= wdata[SW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        en_mask <= '0;
      else if (we && addr == AW'(NUM_Q)) en_mask <= wdata;
   end
endmodule

// File: rtl/cqia_aggregator.sv
module cqia_aggregator
   import cqia_pkg::*;
#(
   parameter int NUM_Q    = 4,
   parameter int NUM_BITS = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_Q-1:0]       up,
   input  logic [NUM_Q-1:0]       down,
   input  logic [NUM_Q-1:0]       nxt_ne,
   input  logic [NUM_Q*clog2_min1(NUM_BITS)-1:0] sel_flat,
   output logic [NUM_BITS-1:0]    status
);
   localparam int SW = clog2_min1(NUM_BITS);

   logic [NUM_BITS-1:0] set_v, clr_v, keep_v;

   for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
      always_comb begin
         set_v[b]  = 1'b0;
         clr_v[b]  = 1'b0;
         keep_v[b] = 1'b0;
         for (int q = 0; q < NUM_Q; q++) begin
            if (sel_flat[q*SW +: SW] == SW'(b)) begin
               set_v[b]  = set_v[b]  | up[q];
               clr_v[b]  = clr_v[b]  | down[q];
               keep_v[b] = keep_v[b] | nxt_ne[q];
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)        status[b] <= 1'b0;
         else if (set_v[b]) status[b] <= 1'b1;
         else if (clr_v[b] && !keep_v[b]) status[b] <= 1'b0;
      end

      AST_SET_ON_UP: assert property (@(posedge clk) disable iff (!rst_n)
         set_v[b] |=> status[b]); // R3
      AST_FALL_NEEDS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(status[b]) |-> $past(clr_v[b])); // R5
      AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (status[b] && keep_v[b]) |=> status[b]); // R6
   end
endmodule

// File: rtl/cqia_top.sv
module cqia_top
   import cqia_pkg::*;
#(
   parameter int NUM_Q    = 4,
   parameter int DEPTH    = 16,
   parameter int PTR_W    = 32,
   parameter int NUM_BITS = 8,
   localparam int QW      = clog2_min1(NUM_Q),
   localparam int AW      = clog2_min1(NUM_Q + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                push_en,
   input  logic [QW-1:0]       push_qid,
   input  logic [PTR_W-1:0]    push_ptr,
   input  logic                pop_en,
   input  logic [QW-1:0]       pop_qid,
   output logic [PTR_W-1:0]    pop_ptr,
   input  logic                cfg_we,
   input  logic [AW-1:0]       cfg_addr,
   input  logic [NUM_BITS-1:0] cfg_wdata,
   output logic [NUM_Q-1:0]    q_pending,
   output logic [NUM_Q-1:0]    q_up,
   output logic [NUM_Q-1:0]    q_down,
   output logic [NUM_Q-1:0]    q_overflow,
   output logic [NUM_Q-1:0]    q_underflow,
   output logic [NUM_BITS-1:0] irq_status,
   output logic                irq
);
   localparam int SW = clog2_min1(NUM_BITS);

   if (NUM_Q < 1)     begin : g_bad_q     $error("NUM_Q must be at least 1"); end
   if (DEPTH < 2)     begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (NUM_BITS < 2)  begin : g_bad_bits  $error("NUM_BITS must be at least 2"); end
   if (PTR_W < 1)     begin : g_bad_ptr   $error("PTR_W must be at least 1"); end

   logic [PTR_W-1:0]      head_a [NUM_Q];
   logic [NUM_Q-1:0]      nxt_ne;
   logic [NUM_Q*SW-1:0]   sel_flat;
   logic [NUM_BITS-1:0]   en_mask;

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      cqia_ptr_fifo #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_fifo (
         .clk           (clk),
         .rst_n         (rst_n),
         .push          (push_en && push_qid == QW'(q)),
         .pop           (pop_en && pop_qid == QW'(q)),
         .din           (push_ptr),
         .head          (head_a[q]),
         .not_empty     (q_pending[q]),
         .nxt_not_empty (nxt_ne[q]),
         .up_evt        (q_up[q]),
         .down_evt      (q_down[q]),
         .ovf           (q_overflow[q]),
         .unf           (q_underflow[q])
      );
   end

   cqia_cfg_regs #(.NUM_Q(NUM_Q), .NUM_BITS(NUM_BITS)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .sel_flat (sel_flat),
      .en_mask  (en_mask)
   );

   cqia_aggregator #(.NUM_Q(NUM_Q), .NUM_BITS(NUM_BITS)) u_agg (
      .clk      (clk),
      .rst_n    (rst_n),
      .up       (q_up),
      .down     (q_down),
      .nxt_ne   (nxt_ne),
      .sel_flat (sel_flat),
      .status   (irq_status)
   );

   assign irq = |(irq_status & en_mask);

   logic pop_hit;
   always_comb begin
      pop_hit = 1'b0;
      for (int q = 0; q < NUM_Q; q++)
         if (pop_qid == QW'(q) && q_pending[q]) pop_hit = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pop_ptr <= '0;
      else if (pop_en)
         pop_ptr <= pop_hit ? head_a[pop_qid] : '0;
   end

   AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en && !pop_hit) |=> (pop_ptr == '0)); // R8
   AST_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_en |=> $stable(pop_ptr)); // R2
endmodule

// File: tb/tb_cqia_top.sv
module tb_cqia_top;
   localparam int NUM_Q = 4, DEPTH = 16, PTR_W = 32, NUM_BITS = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_en = 1'b0, pop_en = 1'b0, cfg_we = 1'b0;
   logic [1:0] push_qid = '0, pop_qid = '0;
   logic [2:0] cfg_addr = '0;
   logic [PTR_W-1:0] push_ptr = '0;
   logic [NUM_BITS-1:0] cfg_wdata = '0;
   logic [PTR_W-1:0] pop_ptr;
   logic [NUM_Q-1:0] q_pending, q_up, q_down, q_overflow, q_underflow;
   logic [NUM_BITS-1:0] irq_status;
   logic irq;
   logic [NUM_Q-1:0] ev_up, ev_down;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cqia_top #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .PTR_W(PTR_W), .NUM_BITS(NUM_BITS)) dut (
      .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_qid(push_qid),
      .push_ptr(push_ptr), .pop_en(pop_en), .pop_qid(pop_qid), .pop_ptr(pop_ptr),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .q_pending(q_pending), .q_up(q_up), .q_down(q_down),
      .q_overflow(q_overflow), .q_underflow(q_underflow),
      .irq_status(irq_status), .irq(irq)
   );

   task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", what, got, exp);
      end
   endtask

   // one clock: inputs driven at negedge, events sampled before the edge,
   // registered outputs sampled 1 ns after the edge
   task automatic cyc(input bit pu, input int pq, input logic [31:0] pd,
                      input bit po, input int oq);
      @(negedge clk);
      push_en = pu; push_qid = 2'(pq); push_ptr = pd;
      pop_en = po; pop_qid = 2'(oq);
      #1; ev_up = q_up; ev_down = q_down;
      @(posedge clk); #1;
      push_en = 1'b0; pop_en = 1'b0;
   endtask

   task automatic wr_cfg(input int a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 reset pending", 32'(q_pending), 0);
      chk("R4 reset irq", 32'(irq), 0);
      chk("R10 reset status", 32'(irq_status), 0);
      chk("R2 reset pop_ptr", pop_ptr, 0);
      chk("R7 reset overflow", 32'(q_overflow), 0);
   endtask

   task automatic t_basic();
      cyc(1, 0, 32'hA1, 0, 0);
      chk("R3 up on first push", 32'(ev_up), 32'b0001);
      chk("R1 pending q0", 32'(q_pending), 32'b0001);
      chk("R3 status bit0 set", 32'(irq_status), 32'h01);
      chk("R4 irq asserted", 32'(irq), 1);
      cyc(1, 0, 32'hB2, 0, 0);
      chk("R3 no up on non-empty push", 32'(ev_up), 0);
      cyc(1, 0, 32'hC3, 0, 0);
      cyc(0, 0, 0, 1, 0);
      chk("R2 pop first", pop_ptr, 32'hA1);
      chk("R5 no early down", 32'(ev_down), 0);
      cyc(0, 0, 0, 1, 0);
      chk("R2 pop second", pop_ptr, 32'hB2);
      cyc(0, 0, 0, 1, 0);
      chk("R2 pop third", pop_ptr, 32'hC3);
      chk("R5 down on drain", 32'(ev_down), 32'b0001);
      chk("R5 status cleared", 32'(irq_status), 0);
      chk("R5 irq dropped", 32'(irq), 0);
      chk("R1 pending clear", 32'(q_pending), 0);
      repeat (2) cyc(0, 0, 0, 0, 0);
      chk("R2 pop_ptr held", pop_ptr, 32'hC3);
   endtask

   task automatic t_shared();
      wr_cfg(3, 8'd1); // queue 3 onto status bit 1, shared with queue 1
      cyc(1, 1, 32'h11, 0, 0);
      cyc(1, 3, 32'h33, 0, 0);
      chk("R6 shared bit set", 32'(irq_status), 32'h02);
      cyc(0, 0, 0, 1, 1);
      chk("R6 q1 down seen", 32'(ev_down), 32'b0010);
      chk("R6 bit held while q3 busy", 32'(irq_status), 32'h02);
      chk("R6 irq held", 32'(irq), 1);
      cyc(0, 0, 0, 1, 3);
      chk("R6 bit cleared when all empty", 32'(irq_status), 0);
      chk("R6 irq low", 32'(irq), 0);
   endtask

   task automatic t_enable();
      wr_cfg(4, 8'hFB); // mask bit 2 off
      cyc(1, 2, 32'h22, 0, 0);
      chk("R10 default map q2->bit2", 32'(irq_status), 32'h04);
      chk("R4 masked bit no irq", 32'(irq), 0);
      wr_cfg(4, 8'hFF);
      chk("R4 unmask raises irq", 32'(irq), 1);
      cyc(0, 0, 0, 1, 2);
      chk("R4 irq low after drain", 32'(irq), 0);
   endtask

   task automatic t_remap();
      wr_cfg(0, 8'd5);
      cyc(1, 0, 32'h55, 0, 0);
      chk("R10 remapped q0->bit5", 32'(irq_status), 32'h20);
      cyc(0, 0, 0, 1, 0);
      chk("R10 remapped bit cleared", 32'(irq_status), 0);
   endtask

   task automatic t_full();
      for (int i = 0; i < DEPTH; i++) cyc(1, 0, 32'(100 + i), 0, 0);
      chk("R7 no overflow at exactly full", 32'(q_overflow), 0);
      cyc(1, 0, 32'h999, 0, 0);
      chk("R7 overflow sticky", 32'(q_overflow), 32'b0001);
      for (int i = 0; i < DEPTH; i++) begin
         cyc(0, 0, 0, 1, 0);
         chk("R7 contents intact", pop_ptr, 32'(100 + i));
      end
      chk("R7 empty after drain", 32'(q_pending), 0);
      cyc(0, 0, 0, 0, 0);
      chk("R7 overflow still set", 32'(q_overflow), 32'b0001);
   endtask

   task automatic t_underflow();
      cyc(0, 0, 0, 1, 2);
      chk("R8 empty pop returns zero", pop_ptr, 0);
      chk("R8 underflow flag", 32'(q_underflow), 32'b0100);
      chk("R8 no status change", 32'(irq_status), 0);
   endtask

   task automatic t_swap();
      cyc(1, 1, 32'h71, 0, 0);
      cyc(1, 1, 32'h72, 1, 1);
      chk("R9 no up on swap", 32'(ev_up), 0);
      chk("R9 no down on swap", 32'(ev_down), 0);
      chk("R9 popped old", pop_ptr, 32'h71);
      chk("R9 still pending", 32'(q_pending), 32'b0010);
      chk("R9 status kept", 32'(irq_status), 32'h02);
      cyc(0, 0, 0, 1, 1);
      chk("R9 new pointer remains", pop_ptr, 32'h72);
      chk("R9 drained", 32'(q_pending), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      t_reset();
      wr_cfg(4, 8'hFF);
      t_basic();
      t_shared();
      t_enable();
      t_remap();
      t_full();
      t_underflow();
      t_swap();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule